// File: doc/BRIEF.md
# Masked Event Flags with Acknowledge Readout

This block keeps an 8-bit register of pending events and an 8-bit enable mask. It drives one interrupt line, which is asserted while any pending event is also enabled. Three sources raise events: a periodic one-second tick, a reply that an attached input device has produced on request, and a reply that an automatic poll of that device has produced. A reply arrives with its length and its bytes, and the block buffers them.

A host works the block through a small command port. One command replaces the enable mask. The other is an acknowledge, which returns a readout packet and clears the flags that the packet reports. If a device reply is pending, the packet holds a status byte with only the two device-related flags, followed by the buffered reply bytes. Only those two flags are cleared. If no device reply is pending, the packet is one byte that holds every pending flag, and all flags are cleared. The packet leaves the block one byte per cycle, with a marker on the final byte. The device bus, the tick timer and the command transport are outside the block.

Top module: `evt_ack_unit`

## Requirements
- R1: The interrupt output is asserted while (pending AND mask) is nonzero and deasserted otherwise. It changes in the cycle after the flag or mask change that causes it. With the default polarity the output is active low.
- R2: After reset, the mask is 0x30 (device reply and tick enabled), all pending flags are clear, the interrupt output is deasserted and no response byte is driven.
- R3: A command with opcode 0xA2 and an argument count of exactly 1 replaces the mask with the argument byte. Opcode 0xA2 with any other count leaves the mask unchanged.
- R4: Each cycle in which the tick input is high sets pending bit 5.
- R5: A reply that is not an autopoll reply (reply valid with the autopoll qualifier low) always stores its length, clamped to the buffer depth, and its bytes, and sets pending bit 4.
- R6: An autopoll reply sets bits 4 and 2 and stores its bytes only if bit 4 was clear before that cycle and no direct reply arrives in the same cycle. Otherwise it is dropped and the buffer is left as it was.
- R7: An acknowledge (opcode 0xA1, argument count 0) issued while bit 4 is clear returns one byte that equals the whole pending register, marked last, and clears all flags.
- R8: An acknowledge issued while bit 4 is set returns first the pending register ANDed with 0x14. The stored reply bytes follow, starting with the byte in reply data bits [7:0]. Only bits 4 and 2 are cleared, and the stored length becomes zero.
- R9: An acknowledge with a nonzero argument count, and any opcode other than 0xA1 or 0xA2, produces no response and changes no flag or mask.
- R10: An event that arrives in the same cycle as an acknowledge stays pending after that acknowledge.
- R11: Response bytes come out in consecutive cycles, with the last-byte marker asserted only on the final byte. Commands presented while a response byte is being driven are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second tick pulse |
| rep_valid_i | input | 1 | A device reply is offered this cycle |
| rep_auto_i | input | 1 | The offered reply comes from an automatic poll |
| rep_len_i | input | LENW (4) | Number of reply bytes |
| rep_data_i | input | MAXR*8 (64) | Reply bytes; byte k in bits [8k+7:8k] |
| cmd_valid_i | input | 1 | A command is presented this cycle |
| cmd_op_i | input | 8 | Command opcode |
| cmd_argc_i | input | 8 | Number of argument bytes |
| cmd_arg_i | input | 8 | First argument byte |
| rsp_valid_o | output | 1 | A response byte is driven |
| rsp_data_o | output | 8 | Response byte |
| rsp_last_o | output | 1 | Final byte of the response |
| irq_o | output | 1 | Interrupt line (active low by default) |

## Verification
The acknowledge is exercised with only a tick pending, with a direct reply plus a tick, with an autopoll reply, with an empty register and with a zero-length reply. This separates the one-byte path from the reply path and shows which flags each path clears. The mask is exercised with a count of one, a count of two and a cleared mask, which separates a flag being pending from the interrupt being raised. Collision patterns check whether events are kept when they meet an acknowledge: a tick in the same cycle as an acknowledge, an autopoll reply while a reply is still pending, and a second acknowledge issued during a stream.

// File: rtl/evtack_pkg.sv
package evtack_pkg;
   localparam int FLAG_W   = 8;
   localparam int BIT_AUTO = 2;
   localparam int BIT_DEV  = 4;
   localparam int BIT_TICK = 5;
   localparam logic [FLAG_W-1:0] DEV_GROUP  = (FLAG_W'(1) << BIT_DEV) | (FLAG_W'(1) << BIT_AUTO);
   localparam logic [FLAG_W-1:0] MASK_RESET = (FLAG_W'(1) << BIT_DEV) | (FLAG_W'(1) << BIT_TICK);
   localparam logic [7:0] OP_ACK  = 8'hA1;
   localparam logic [7:0] OP_MASK = 8'hA2;

   typedef enum logic [1:0] {
      CMD_NONE = 2'd0,
      CMD_ACK  = 2'd1,
      CMD_MASK = 2'd2
   } cmd_kind_t;
endpackage

// File: rtl/evtack_decode.sv
module evtack_decode
   import evtack_pkg::*;
(
   input  logic       cmd_valid,
   input  logic [7:0] cmd_op,
   input  logic [7:0] cmd_argc,
   input  logic       stream_busy,
   output cmd_kind_t  kind
);
   always_comb begin
      kind = CMD_NONE;
      if (cmd_valid && !stream_busy) begin
         if (cmd_op == OP_ACK && cmd_argc == 8'd0)
            kind = CMD_ACK;
         else if (cmd_op == OP_MASK && cmd_argc == 8'd1)
            kind = CMD_MASK;
      end
   end
endmodule

// File: rtl/evtack_flags.sv
module evtack_flags
   import evtack_pkg::*;
#(
   parameter bit IRQ_ACTIVE_LOW = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_ev,
   input  logic              dev_ev,
   input  logic              auto_ev,
   input  logic              ack_fire,
   input  logic              mask_fire,
   input  logic [FLAG_W-1:0] mask_val,
   output logic              auto_take,
   output logic [FLAG_W-1:0] pend_o,
   output logic [FLAG_W-1:0] mask_o,
   output logic [FLAG_W-1:0] readout_o,
   output logic              rep_path_o,
   output logic              irq_o
);
   logic [FLAG_W-1:0] pend_q, mask_q, set_v, clr_v, pend_d;
   logic              hit_q;

   assign rep_path_o = pend_q[BIT_DEV];
   assign auto_take  = auto_ev && !pend_q[BIT_DEV] && !dev_ev;

   always_comb begin
      set_v = '0;
      set_v[BIT_TICK] = tick_ev;
      set_v[BIT_DEV]  = dev_ev | auto_take;
      set_v[BIT_AUTO] = auto_take;
   end

   always_comb begin
      clr_v = '0;
      if (ack_fire)
         clr_v = rep_path_o ? DEV_GROUP : {FLAG_W{1'b1}};
   end

   assign pend_d    = (pend_q & ~clr_v) | set_v;
   assign readout_o = rep_path_o ? (pend_q & DEV_GROUP) : pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         mask_q <= MASK_RESET;
         hit_q  <= 1'b0;
      end else begin
         pend_q <= pend_d;
         if (mask_fire) mask_q <= mask_val;
         hit_q  <= |(pend_q & mask_q);
      end
   end

   generate
      if (IRQ_ACTIVE_LOW) begin : g_irq_low
         assign irq_o = ~hit_q;
      end else begin : g_irq_high
         assign irq_o = hit_q;
      end
   endgenerate

   assign pend_o = pend_q;
   assign mask_o = mask_q;

   AST_TICK_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      tick_ev |=> pend_q[BIT_TICK]); // R10

   AST_PLAIN_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_fire && !pend_q[BIT_DEV] && !tick_ev && !dev_ev && !auto_ev) |=> (pend_q == '0)); // R7

   AST_REPLY_KEEPS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_fire && pend_q[BIT_DEV] && pend_q[BIT_TICK]) |=> pend_q[BIT_TICK]); // R8
endmodule

// File: rtl/evtack_rbuf.sv
module evtack_rbuf #(
   parameter int MAXR = 8,
   localparam int LENW = $clog2(MAXR + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              drain,
   input  logic [LENW-1:0]   len_in,
   input  logic [MAXR*8-1:0] data_in,
   input  logic              auto_drop,
   output logic [LENW-1:0]   len_o,
   output logic [MAXR*8-1:0] data_o
);
   logic [LENW-1:0]   len_q, len_clamped;
   logic [MAXR*8-1:0] data_q;

   assign len_clamped = (len_in > LENW'(MAXR)) ? LENW'(MAXR) : len_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q  <= '0;
         data_q <= '0;
      end else if (load) begin
         len_q  <= len_clamped;
         data_q <= data_in;
      end else if (drain) begin
         len_q  <= '0;
      end
   end

   assign len_o  = len_q;
   assign data_o = data_q;

   AST_AUTO_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_drop && !load && !drain) |=> ($stable(len_q) && $stable(data_q))); // R6

   AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> (len_q <= LENW'(MAXR))); // R5
endmodule

// File: rtl/evtack_ser.sv
module evtack_ser #(
   parameter int MAXR = 8,
   localparam int NB  = MAXR + 1,
   localparam int CW  = $clog2(NB + 1)
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [CW-1:0]   count,
   input  logic [NB*8-1:0] bytes_in,
   output logic            valid_o,
   output logic [7:0]      data_o,
   output logic            last_o
);
   logic [7:0]    sh_q [NB];
   logic [CW-1:0] cnt_q;

   genvar gi;
   generate
      for (gi = 0; gi < NB; gi++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sh_q[gi] <= '0;
            else if (load)
               sh_q[gi] <= bytes_in[gi*8 +: 8];
            else if (gi < NB - 1)
               sh_q[gi] <= sh_q[(gi < NB - 1) ? gi + 1 : gi];
            else
               sh_q[gi] <= '0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= count;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign valid_o = (cnt_q != '0);
   assign last_o  = (cnt_q == CW'(1));
   assign data_o  = sh_q[0];

   AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o); // R11

   AST_STREAM_GAPLESS: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !last_o) |=> valid_o); // R11

   AST_NO_LOAD_MIDSTREAM: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> !load); // R11
endmodule

// File: rtl/evt_ack_unit.sv
module evt_ack_unit
   import evtack_pkg::*;
#(
   parameter int MAXR = 8,
   parameter bit IRQ_ACTIVE_LOW = 1'b1,
   localparam int LENW = $clog2(MAXR + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              rep_valid_i,
   input  logic              rep_auto_i,
   input  logic [LENW-1:0]   rep_len_i,
   input  logic [MAXR*8-1:0] rep_data_i,
   input  logic              cmd_valid_i,
   input  logic [7:0]        cmd_op_i,
   input  logic [7:0]        cmd_argc_i,
   input  logic [7:0]        cmd_arg_i,
   output logic              rsp_valid_o,
   output logic [7:0]        rsp_data_o,
   output logic              rsp_last_o,
   output logic              irq_o
);
   localparam int NB = MAXR + 1;
   localparam int CW = $clog2(NB + 1);

   generate
      if (MAXR < 1 || MAXR > 32) begin : g_bad_depth
         $error("evt_ack_unit: MAXR must lie in 1..32");
      end
   endgenerate

   cmd_kind_t         kind;
   logic              ack_fire, mask_fire, dev_ev, auto_ev, auto_take, rep_path;
   logic [FLAG_W-1:0] pend, mask, readout;
   logic [LENW-1:0]   buf_len;
   logic [MAXR*8-1:0] buf_data;
   logic [NB*8-1:0]   pkt;
   logic [CW-1:0]     pkt_cnt;

   assign dev_ev  = rep_valid_i && !rep_auto_i;
   assign auto_ev = rep_valid_i && rep_auto_i;

   evtack_decode u_dec (
      .cmd_valid   (cmd_valid_i),
      .cmd_op      (cmd_op_i),
      .cmd_argc    (cmd_argc_i),
      .stream_busy (rsp_valid_o),
      .kind        (kind)
   );

   assign ack_fire  = (kind == CMD_ACK);
   assign mask_fire = (kind == CMD_MASK);

   evtack_flags #(.IRQ_ACTIVE_LOW(IRQ_ACTIVE_LOW)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_ev    (tick_i),
      .dev_ev     (dev_ev),
      .auto_ev    (auto_ev),
      .ack_fire   (ack_fire),
      .mask_fire  (mask_fire),
      .mask_val   (cmd_arg_i),
      .auto_take  (auto_take),
      .pend_o     (pend),
      .mask_o     (mask),
      .readout_o  (readout),
      .rep_path_o (rep_path),
      .irq_o      (irq_o)
   );

   evtack_rbuf #(.MAXR(MAXR)) u_rbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (dev_ev || auto_take),
      .drain     (ack_fire && rep_path),
      .len_in    (rep_len_i),
      .data_in   (rep_data_i),
      .auto_drop (auto_ev && !auto_take),
      .len_o     (buf_len),
      .data_o    (buf_data)
   );

   assign pkt     = {buf_data, readout};
   assign pkt_cnt = rep_path ? (CW'(buf_len) + CW'(1)) : CW'(1);

   evtack_ser #(.MAXR(MAXR)) u_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ack_fire),
      .count    (pkt_cnt),
      .bytes_in (pkt),
      .valid_o  (rsp_valid_o),
      .data_o   (rsp_data_o),
      .last_o   (rsp_last_o)
   );

   AST_BAD_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && cmd_op_i == OP_MASK && cmd_argc_i != 8'd1) |=> $stable(mask)); // R3

   AST_GOOD_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && !rsp_valid_o && cmd_op_i == OP_MASK && cmd_argc_i == 8'd1)
      |=> (mask == $past(cmd_arg_i))); // R3

   AST_PLAIN_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_fire && !pend[BIT_DEV]) |=> (rsp_valid_o && rsp_last_o)); // R7

   AST_BAD_ACK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && cmd_op_i == OP_ACK && cmd_argc_i != 8'd0 && !rsp_valid_o) |=> !rsp_valid_o); // R9
endmodule

// File: tb/evt_ack_unit_test.sv
module evt_ack_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam int MAXR = 8;
   localparam int LENW = $clog2(MAXR + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick_i = 1'b0;
   logic              rep_valid_i = 1'b0;
   logic              rep_auto_i = 1'b0;
   logic [LENW-1:0]   rep_len_i = '0;
   logic [MAXR*8-1:0] rep_data_i = '0;
   logic              cmd_valid_i = 1'b0;
   logic [7:0]        cmd_op_i = '0;
   logic [7:0]        cmd_argc_i = '0;
   logic [7:0]        cmd_arg_i = '0;
   logic              rsp_valid_o, rsp_last_o, irq_o;
   logic [7:0]        rsp_data_o;

   int n_checks = 0;
   int n_fail = 0;
   int exp_q[$];   // {tag[15:0], last, data[7:0]}

   always #(CLK_PERIOD/2) clk = ~clk;

   evt_ack_unit #(.MAXR(MAXR)) uut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .rep_valid_i(rep_valid_i), .rep_auto_i(rep_auto_i),
      .rep_len_i(rep_len_i), .rep_data_i(rep_data_i),
      .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
      .cmd_argc_i(cmd_argc_i), .cmd_arg_i(cmd_arg_i),
      .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o),
      .rsp_last_o(rsp_last_o), .irq_o(irq_o)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic expect_byte(input int tag, input logic [7:0] d, input logic last);
      exp_q.push_back((tag << 9) | (int'(last) << 8) | int'(d));
   endtask

   // monitor: pops the scoreboard as response bytes appear
   always @(negedge clk) begin
      if (rst_n && rsp_valid_o) begin
         n_checks++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R11: unexpected byte actual %0h expected none", rsp_data_o);
         end else begin
            int e;
            e = exp_q.pop_front();
            if ({rsp_last_o, rsp_data_o} != e[8:0]) begin
               n_fail++;
               $display("FAIL R%0d: actual last=%0b data=%0h expected last=%0b data=%0h",
                        e >> 9, rsp_last_o, rsp_data_o, e[8], e[7:0]);
            end
         end
      end
   end

   task automatic tick();
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
   endtask

   task automatic reply(input logic au, input int len, input logic [MAXR*8-1:0] d);
      rep_valid_i = 1'b1; rep_auto_i = au; rep_len_i = LENW'(len); rep_data_i = d;
      @(negedge clk);
      rep_valid_i = 1'b0; rep_auto_i = 1'b0;
   endtask

   task automatic cmd(input logic [7:0] op, input logic [7:0] argc, input logic [7:0] arg);
      cmd_valid_i = 1'b1; cmd_op_i = op; cmd_argc_i = argc; cmd_arg_i = arg;
      @(negedge clk);
      cmd_valid_i = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drained(input string req);
      idle(MAXR + 3);
      check(req, exp_q.size(), 0);
      exp_q.delete();
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin : stim
      idle(2);
      // R2: reset state
      check("R2 irq idle", int'(irq_o), 1);
      check("R2 no response", int'(rsp_valid_o), 0);
      rst_n = 1'b1;
      idle(2);
      check("R2 irq after release", int'(irq_o), 1);

      // R4 + R1: tick raises interrupt one cycle after the flag
      tick();
      check("R1 irq lag", int'(irq_o), 1);
      idle(1);
      check("R1 R4 irq low on tick", int'(irq_o), 0);

      // R7: plain acknowledge
      expect_byte(7, 8'h20, 1'b1);
      cmd(8'hA1, 8'd0, 8'h00);
      idle(1);
      check("R7 irq released", int'(irq_o), 1);
      drained("R7 drained");

      // R3: bad count leaves mask, tick still interrupts
      cmd(8'hA2, 8'd2, 8'h00);
      tick();
      idle(1);
      check("R3 bad count keeps mask", int'(irq_o), 0);
      expect_byte(3, 8'h20, 1'b1);
      cmd(8'hA1, 8'd0, 8'h00);
      drained("R3 drained");

      // R3 + R1: mask cleared, pending but no interrupt
      cmd(8'hA2, 8'd1, 8'h00);
      tick();
      idle(2);
      check("R1 masked no irq", int'(irq_o), 1);
      cmd(8'hA2, 8'd1, 8'h20);
      idle(1);
      check("R3 R1 unmask raises irq", int'(irq_o), 0);
      expect_byte(3, 8'h20, 1'b1);
      cmd(8'hA1, 8'd0, 8'h00);
      drained("R3 drained 2");
      cmd(8'hA2, 8'd1, 8'h30);

      // R5 + R8: direct reply with tick pending
      tick();
      reply(1'b0, 3, 64'h0000_0000_0033_2211);
      expect_byte(8, 8'h10, 1'b0);
      expect_byte(8, 8'h11, 1'b0);
      expect_byte(8, 8'h22, 1'b0);
      expect_byte(5, 8'h33, 1'b1);
      cmd(8'hA1, 8'd0, 8'h00);
      drained("R8 reply path");
      expect_byte(8, 8'h20, 1'b1);   // tick survived reply-path ack
      cmd(8'hA1, 8'd0, 8'h00);
      drained("R8 tick kept");

      // R6: autopoll reply sets bits 4 and 2
      reply(1'b1, 2, 64'h0000_0000_0000_BBAA);
      idle(1);
      check("R6 irq on autopoll", int'(irq_o), 0);
      expect_byte(6, 8'h14, 1'b0);
      expect_byte(6, 8'hAA, 1'b0);
      expect_byte(6, 8'hBB, 1'b1);
      cmd(8'hA1, 8'd0, 8'h00);
      drained("R6 autopoll");

      // R6: autopoll dropped while a reply is pending
      reply(1'b0, 1, 64'h55);
      reply(1'b1, 1, 64'h66);
      expect_byte(6, 8'h10, 1'b0);
      expect_byte(6, 8'h55, 1'b1);
      cmd(8'hA1, 8'd0, 8'h00);
      drained("R6 dropped");

      // R9: acknowledge with arguments and unknown opcode are ignored
      tick();
      cmd(8'hA1, 8'd1, 8'h00);
      cmd(8'h5C, 8'd0, 8'h00);
      idle(3);
      check("R9 no response", int'(rsp_valid_o), 0);
      check("R9 flags kept", int'(irq_o), 0);
      expect_byte(9, 8'h20, 1'b1);
      cmd(8'hA1, 8'd0, 8'h00);
      drained("R9 drained");

      // R10: tick in the same cycle as an acknowledge stays pending
      tick();
      expect_byte(10, 8'h20, 1'b1);
      tick_i = 1'b1;
      cmd(8'hA1, 8'd0, 8'h00);
      tick_i = 1'b0;
      idle(1);
      check("R10 irq still low", int'(irq_o), 0);
      drained("R10 first");
      expect_byte(10, 8'h20, 1'b1);
      cmd(8'hA1, 8'd0, 8'h00);
      drained("R10 second");

      // R7: empty register
      expect_byte(7, 8'h00, 1'b1);
      cmd(8'hA1, 8'd0, 8'h00);
      drained("R7 empty");

      // R11: second ack during a stream is ignored
      tick();
      reply(1'b0, 3, 64'h0000_0000_0077_6655);
      expect_byte(11, 8'h10, 1'b0);
      expect_byte(11, 8'h55, 1'b0);
      expect_byte(11, 8'h66, 1'b0);
      expect_byte(11, 8'h77, 1'b1);
      cmd(8'hA1, 8'd0, 8'h00);
      cmd(8'hA1, 8'd0, 8'h00);
      drained("R11 ignored");
      expect_byte(11, 8'h20, 1'b1);
      cmd(8'hA1, 8'd0, 8'h00);
      drained("R11 after");

      // R5: zero-length and over-long replies
      reply(1'b0, 0, 64'hFF);
      expect_byte(5, 8'h10, 1'b1);
      cmd(8'hA1, 8'd0, 8'h00);
      drained("R5 zero length");
      reply(1'b0, 15, 64'h8877_6655_4433_2211);
      expect_byte(5, 8'h10, 1'b0);
      for (int k = 1; k <= 8; k++)
         expect_byte(5, 8'(k * 8'h11), k == 8);
      cmd(8'hA1, 8'd0, 8'h00);
      drained("R5 clamp");
      check("R1 final irq idle", int'(irq_o), 1);

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule